// File: doc/BRIEF.md
# Running Timestamp Estimator

This block keeps a running estimate of a free-running timestamp counter. It works from a stream of decoded timing packets. A full timestamp packet carries an exact 56-bit value, and the block loads that value directly into the estimate.

Crystal-tick packets carry an 8-bit payload that follows a slower crystal clock. The first tick after a load only records its payload. Each later tick works out how many crystal periods have passed since the previous tick:
- It takes the wrapping difference of the two payloads.
- It shifts that difference left by a programmed period exponent.
- It multiplies the result by the programmed integer ratio of timestamp frequency to crystal frequency.
- It adds the product to the estimate.

A trace decoder uses the block to attach an approximate time to every point between two infrequent full timestamp packets. The estimate is marked valid once the first full timestamp packet after reset has arrived.

Top module: `ts_estimator`

## Requirements
- R1: After reset, `estValid` is 0 and `estValue` is 0.
- R2: A cycle with `fullValid` high makes `estValue` equal to `fullValue` and `estValid` equal to 1 from the next clock edge on.
- R3: Until the first full packet after reset, tick packets have no effect: `estValid` stays 0 and `estValue` stays 0. Payloads seen in this period are not recorded, so the first tick after the first full packet does not advance the estimate.
- R4: The first tick packet after a full packet only records its payload and leaves `estValue` unchanged.
- R5: Each later tick packet adds ((new payload − previous payload) mod 256) × 2^`periodExp` × `ratio` to `estValue`, visible after the next clock edge. Equal payloads add 0.
- R6: If `fullValid` and `tickValid` are high in the same cycle, the full packet wins and the tick is discarded, so the next tick again only records its payload.
- R7: In a cycle with neither packet valid, `estValue` and `estValid` keep their values.
- R8: `estValue` wraps modulo 2^56.
- R9: `periodExp` scales the crystal delta by a left shift, so a payload difference of 10 with `periodExp` = 2 counts as 40 crystal periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fullValid | input | 1 | Full timestamp packet present |
| fullValue | input | 56 | Exact timestamp carried by the packet |
| tickValid | input | 1 | Crystal-tick packet present |
| tickPayload | input | 8 | Crystal-tick payload |
| ratio | input | 16 | Integer timestamp-to-crystal frequency ratio |
| periodExp | input | 4 | Crystal period exponent (left shift of the delta) |
| estValid | output | 1 | Estimate is valid |
| estValue | output | 56 | Current timestamp estimate |

## Verification
The remembered previous payload and the "have a previous payload" flag are the hidden state. A stale payload appears at the ports as a wrong increment on the very next tick. A wrong flag shows either as an advance on the first tick after a load, or as a missing advance on the second tick.

Both faults become visible one clock after the tick that exposes them. The bench therefore checks the estimate after every single packet rather than only at the end of a sequence.

// File: rtl/ts_est_pkg.sv
package ts_est_pkg;
  typedef struct packed {
    logic loadFull;
    logic recordTick;
    logic advance;
  } estStrobes_t;
endpackage

// File: rtl/ts_est_ctrl.sv
module ts_est_ctrl
  import ts_est_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fullValid,
  input  logic        tickValid,
  output estStrobes_t strobes,
  output logic        estValid
);
  logic havePrev;

  always_comb begin
    strobes            = '0;
    strobes.loadFull   = fullValid;
    strobes.recordTick = !fullValid && tickValid && estValid;
    strobes.advance    = strobes.recordTick && havePrev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      estValid <= 1'b0;
      havePrev <= 1'b0;
    end else if (strobes.loadFull) begin
      estValid <= 1'b1;
      havePrev <= 1'b0;
    end else if (strobes.recordTick) begin
      havePrev <= 1'b1;
    end
  end
endmodule

// File: rtl/ts_est_datapath.sv
module ts_est_datapath
  import ts_est_pkg::*;
#(
  parameter int TS_W    = 56,
  parameter int PAY_W   = 8,
  parameter int RATIO_W = 16,
  parameter int EXP_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  estStrobes_t        strobes,
  input  logic [TS_W-1:0]    fullValue,
  input  logic [PAY_W-1:0]   tickPayload,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [EXP_W-1:0]   periodExp,
  output logic [TS_W-1:0]    estValue
);
  localparam int SHIFT_W = PAY_W + (1 << EXP_W) - 1;
  localparam int PROD_W  = SHIFT_W + RATIO_W;

  logic [PAY_W-1:0]   prevPayload;
  logic [PAY_W-1:0]   tickDelta;
  logic [SHIFT_W-1:0] scaledDelta;
  logic [PROD_W-1:0]  product;
  logic [TS_W-1:0]    increment;

  always_comb begin
    tickDelta   = tickPayload - prevPayload;
    scaledDelta = SHIFT_W'(tickDelta) << periodExp;
    product     = PROD_W'(scaledDelta) * PROD_W'(ratio);
    increment   = TS_W'(product);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      estValue    <= '0;
      prevPayload <= '0;
    end else if (strobes.loadFull) begin
      estValue <= fullValue;
    end else if (strobes.recordTick) begin
      prevPayload <= tickPayload;
      if (strobes.advance) estValue <= estValue + increment;
    end
  end
endmodule

// File: rtl/ts_estimator.sv
module ts_estimator
  import ts_est_pkg::*;
#(
  parameter int TS_W    = 56,
  parameter int PAY_W   = 8,
  parameter int RATIO_W = 16,
  parameter int EXP_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fullValid,
  input  logic [TS_W-1:0]    fullValue,
  input  logic               tickValid,
  input  logic [PAY_W-1:0]   tickPayload,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [EXP_W-1:0]   periodExp,
  output logic               estValid,
  output logic [TS_W-1:0]    estValue
);
  estStrobes_t strobes;

  ts_est_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fullValid(fullValid), .tickValid(tickValid),
    .strobes(strobes), .estValid(estValid)
  );

  ts_est_datapath #(.TS_W(TS_W), .PAY_W(PAY_W), .RATIO_W(RATIO_W), .EXP_W(EXP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .fullValue(fullValue),
    .tickPayload(tickPayload), .ratio(ratio), .periodExp(periodExp),
    .estValue(estValue)
  );
endmodule

// File: rtl/ts_estimator_chk.sv
module ts_estimator_chk #(
  parameter int TS_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fullValid,
  input logic [TS_W-1:0] fullValue,
  input logic            tickValid,
  input logic            estValid,
  input logic [TS_W-1:0] estValue
);
  AST_FULL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    fullValid |=> (estValid && estValue == $past(fullValue))); // R2

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    estValid |=> estValid); // R2

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!estValid && !fullValid) |=> (!estValid && estValue == '0)); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fullValid && !tickValid) |=> $stable(estValue)); // R7

  AST_IDLE_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fullValid && !tickValid) |=> $stable(estValid)); // R7
endmodule

bind ts_estimator ts_estimator_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fullValid(fullValid), .fullValue(fullValue),
  .tickValid(tickValid), .estValid(estValid), .estValue(estValue)
);

// File: tb/ts_estimator_tb.sv
module ts_estimator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fullValid = 1'b0;
  logic [55:0] fullValue = '0;
  logic        tickValid = 1'b0;
  logic [7:0]  tickPayload = '0;
  logic [15:0] ratio = 16'd100;
  logic [3:0]  periodExp = '0;
  logic        estValid;
  logic [55:0] estValue;
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ts_estimator u_dut (
    .clk(clk), .rst_n(rst_n), .fullValid(fullValid), .fullValue(fullValue),
    .tickValid(tickValid), .tickPayload(tickPayload), .ratio(ratio),
    .periodExp(periodExp), .estValid(estValid), .estValue(estValue)
  );

  task automatic check(string req, logic expValid, logic [55:0] expValue);
    compared++;
    if (estValid !== expValid || estValue !== expValue) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b value=%0d, expected valid=%0b value=%0d",
               req, estValid, estValue, expValid, expValue);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    fullValid = 1'b0;
    tickValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sendFull(logic [55:0] v);
    fullValid = 1'b1;
    fullValue = v;
    @(negedge clk);
    fullValid = 1'b0;
  endtask

  task automatic sendTick(logic [7:0] p);
    tickValid = 1'b1;
    tickPayload = p;
    @(negedge clk);
    tickValid = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1", 1'b0, 56'd0);
  endtask

  task automatic testEarlyTicks();
    doReset();
    sendTick(8'd40);
    check("R3", 1'b0, 56'd0);
    sendTick(8'd90);
    check("R3", 1'b0, 56'd0);
    sendFull(56'd5);
    check("R2", 1'b1, 56'd5);
    sendTick(8'd9);
    check("R3 first tick after first full records only", 1'b1, 56'd5);
  endtask

  task automatic testAdvance();
    doReset();
    ratio = 16'd100;
    periodExp = 4'd0;
    sendFull(56'd1000);
    check("R2", 1'b1, 56'd1000);
    sendTick(8'd10);
    check("R4", 1'b1, 56'd1000);
    sendTick(8'd25);
    check("R5", 1'b1, 56'd2500);
    sendTick(8'd3);
    check("R5 payload wrap", 1'b1, 56'd25900);
    sendTick(8'd3);
    check("R5 equal payloads", 1'b1, 56'd25900);
    repeat (3) @(negedge clk);
    check("R7", 1'b1, 56'd25900);
    sendFull(56'd77);
    check("R2 reload", 1'b1, 56'd77);
    sendTick(8'd50);
    check("R4 after reload", 1'b1, 56'd77);
  endtask

  task automatic testScale();
    doReset();
    ratio = 16'd7;
    periodExp = 4'd2;
    sendFull(56'd0);
    sendTick(8'd250);
    sendTick(8'd4);
    check("R9", 1'b1, 56'd280);
  endtask

  task automatic testPriority();
    doReset();
    ratio = 16'd3;
    periodExp = 4'd0;
    sendFull(56'd10);
    sendTick(8'd1);
    fullValid = 1'b1;
    fullValue = 56'd500;
    tickValid = 1'b1;
    tickPayload = 8'd20;
    @(negedge clk);
    fullValid = 1'b0;
    tickValid = 1'b0;
    check("R6", 1'b1, 56'd500);
    sendTick(8'd30);
    check("R6 tick discarded", 1'b1, 56'd500);
    sendTick(8'd31);
    check("R6", 1'b1, 56'd503);
  endtask

  task automatic testWrap();
    logic [55:0] start;
    start = 56'hFF_FFFF_FFFF_FFCE;
    doReset();
    ratio = 16'd10;
    periodExp = 4'd0;
    sendFull(start);
    sendTick(8'd0);
    sendTick(8'd10);
    check("R8", 1'b1, 56'd50);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    testReset();
    testEarlyTicks();
    testAdvance();
    testScale();
    testPriority();
    testWrap();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule